// File: doc/BRIEF.md
# Sliced-View General Register File

This block holds sixteen 64-bit general registers for an integer datapath. Each register can be reached through narrower overlapping views: the full 64 bits, the low 32 bits, the low 16 bits, and byte views. Registers 0 to 3 offer two byte views, the low byte (bits 7:0) and the second byte (bits 15:8). Registers 8 to 15 offer only the low byte. Registers 4 to 7 serve as pointer and index registers and have no byte view at all.

The file has two combinational read ports and one write port that commits on the rising clock edge. Each port carries a register index, a 2-bit access size and a second-byte select. Reads return the chosen slice zero-extended to 64 bits. Each write width has its own rule for the bits it does not cover. A byte view that does not exist is flagged as illegal, and an illegal write changes nothing. A read of the register that is being written in the same cycle sees the merged new value. The low byte of register 1 is driven out on its own pin, where it serves as the count for variable shifts and rotates.

The ports are plain register-file ports with no handshake. Every read and every write completes in the cycle it is presented, so there is no back-pressure.

Top module: `gpr_slice_file`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero. After reset every read returns zero.
- R2: The size code 3 selects the 64-bit view. A write replaces the whole register, and a read returns it unchanged.
- R3: The size code 2 selects the 32-bit view. A write stores data bits 31:0 and clears bits 63:32. A read returns bits 31:0 with zeros above.
- R4: The size code 1 selects the 16-bit view. A write stores data bits 15:0 and leaves bits 63:16 as they were. A read returns bits 15:0 with zeros above.
- R5: The size code 0 with the select low picks the low-byte view. A write stores data bits 7:0 into bits 7:0 and keeps every other bit. A read returns bits 7:0. This view is legal on registers 0 to 3 and 8 to 15.
- R6: The size code 0 with the select high picks the second-byte view of registers 0 to 3. A write stores data bits 7:0 into register bits 15:8 and keeps every other bit. A read returns register bits 15:8 in result bits 7:0.
- R7: Some byte accesses are illegal: any byte access to registers 4 to 7, and a second-byte access to any register from 4 to 15. For such an access the port's illegal flag is high in the same cycle. An illegal read returns zero. An illegal write leaves every register unchanged. The write flag is low whenever the write enable is low.
- R8: The second-byte select has no effect when the size code is not 0.
- R9: A read whose index matches a legal write in the same cycle returns the slice of the merged value that the write will store.
- R10: The count output always equals bits 7:0 of the stored register 1. A write in the current cycle does not bypass to this output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| wr_hi | input | 1 | Write second-byte select |
| wr_data | input | 64 | Write data, slice taken from the low bits |
| wr_illegal | output | 1 | Write names a byte view that does not exist |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_hi | input | 1 | Read port 0 second-byte select |
| rd0_data | output | 64 | Read port 0 zero-extended slice |
| rd0_illegal | output | 1 | Read port 0 names a byte view that does not exist |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 second-byte select |
| rd1_data | output | 64 | Read port 1 zero-extended slice |
| rd1_illegal | output | 1 | Read port 1 names a byte view that does not exist |
| shift_count | output | 8 | Low byte of stored register 1 |

## Verification
The assertions assume that every control and data input holds a known value on each rising edge outside reset, and that a write request's index, size and select are stable across the whole cycle. The stimulus changes inputs only on falling edges and never leaves a pin undriven. It combines directed sequences on the width rules and the legality map with a long run of random mixed accesses. In that run the read indices are often forced to match the write index, so the bypass path gets exercised under every view.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  typedef enum logic [1:0] {
    ACC_B8  = 2'd0,
    ACC_B16 = 2'd1,
    ACC_B32 = 2'd2,
    ACC_B64 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/gprf_view_check.sv
module gprf_view_check
  import gprf_pkg::*;
#(
  parameter int NREGS       = 16,
  parameter int HIBYTE_REGS = 4,
  parameter int NOBYTE_LO   = 4,
  parameter int NOBYTE_HI   = 7,
  localparam int IW         = $clog2(NREGS)
) (
  input  logic [IW-1:0] idx,
  input  logic [1:0]    size,
  input  logic          hi,
  output logic          illegal
);
  logic is_byte;
  logic in_nobyte;
  logic no_second;

  always_comb begin
    is_byte   = (acc_size_e'(size) == ACC_B8);
    in_nobyte = (idx >= IW'(NOBYTE_LO)) && (idx <= IW'(NOBYTE_HI));
    no_second = hi && (idx >= IW'(HIBYTE_REGS));
    illegal   = is_byte && (in_nobyte || no_second);
  end
endmodule

// File: rtl/gprf_write_merge.sv
module gprf_write_merge
  import gprf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_word,
  input  logic [XLEN-1:0] data,
  input  logic [1:0]      size,
  input  logic            hi,
  output logic [XLEN-1:0] new_word
);
  always_comb begin
    unique case (acc_size_e'(size))
      ACC_B64: new_word = data;
      ACC_B32: new_word = XLEN'(data[31:0]);
      ACC_B16: new_word = {old_word[XLEN-1:16], data[15:0]};
      default: begin
        if (hi) new_word = {old_word[XLEN-1:16], data[7:0], old_word[7:0]};
        else    new_word = {old_word[XLEN-1:8], data[7:0]};
      end
    endcase
  end
endmodule

// File: rtl/gprf_read_slice.sv
module gprf_read_slice
  import gprf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] word,
  input  logic [1:0]      size,
  input  logic            hi,
  input  logic            illegal,
  output logic [XLEN-1:0] slice
);
  always_comb begin
    if (illegal) begin
      slice = '0;
    end else begin
      unique case (acc_size_e'(size))
        ACC_B64: slice = word;
        ACC_B32: slice = XLEN'(word[31:0]);
        ACC_B16: slice = XLEN'(word[15:0]);
        default: slice = hi ? XLEN'(word[15:8]) : XLEN'(word[7:0]);
      endcase
    end
  end
endmodule

// File: rtl/gpr_slice_file.sv
module gpr_slice_file
  import gprf_pkg::*;
#(
  parameter int NREGS       = 16,
  parameter int XLEN        = 64,
  parameter int HIBYTE_REGS = 4,
  parameter int NOBYTE_LO   = 4,
  parameter int NOBYTE_HI   = 7,
  parameter int COUNT_REG   = 1,
  localparam int IW         = $clog2(NREGS),
  localparam int NRD        = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_size,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_illegal,
  input  logic [IW-1:0]   rd0_idx,
  input  logic [1:0]      rd0_size,
  input  logic            rd0_hi,
  output logic [XLEN-1:0] rd0_data,
  output logic            rd0_illegal,
  input  logic [IW-1:0]   rd1_idx,
  input  logic [1:0]      rd1_size,
  input  logic            rd1_hi,
  output logic [XLEN-1:0] rd1_data,
  output logic            rd1_illegal,
  output logic [7:0]      shift_count
);
  logic [XLEN-1:0] regs_q [NREGS];
  logic [NREGS-1:0][XLEN-1:0] regs_flat;
  logic            wr_bad;
  logic            wr_fire;
  logic [XLEN-1:0] wr_next;

  gprf_view_check #(
    .NREGS(NREGS), .HIBYTE_REGS(HIBYTE_REGS),
    .NOBYTE_LO(NOBYTE_LO), .NOBYTE_HI(NOBYTE_HI)
  ) u_wr_view (
    .idx(wr_idx), .size(wr_size), .hi(wr_hi), .illegal(wr_bad)
  );

  gprf_write_merge #(.XLEN(XLEN)) u_merge (
    .old_word(regs_q[wr_idx]), .data(wr_data), .size(wr_size),
    .hi(wr_hi), .new_word(wr_next)
  );

  assign wr_illegal = wr_en && wr_bad;
  assign wr_fire    = wr_en && !wr_bad;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (wr_fire && (wr_idx == IW'(g))) begin
        regs_q[g] <= wr_next;
      end
    end
    assign regs_flat[g] = regs_q[g];
  end

  logic [IW-1:0]   rp_idx  [NRD];
  logic [1:0]      rp_size [NRD];
  logic            rp_hi   [NRD];
  logic [XLEN-1:0] rp_word [NRD];
  logic [XLEN-1:0] rp_data [NRD];
  logic            rp_bad  [NRD];

  assign rp_idx[0]  = rd0_idx;
  assign rp_size[0] = rd0_size;
  assign rp_hi[0]   = rd0_hi;
  assign rp_idx[1]  = rd1_idx;
  assign rp_size[1] = rd1_size;
  assign rp_hi[1]   = rd1_hi;

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    always_comb begin
      if (wr_fire && (rp_idx[p] == wr_idx)) rp_word[p] = wr_next;
      else                                  rp_word[p] = regs_q[rp_idx[p]];
    end

    gprf_view_check #(
      .NREGS(NREGS), .HIBYTE_REGS(HIBYTE_REGS),
      .NOBYTE_LO(NOBYTE_LO), .NOBYTE_HI(NOBYTE_HI)
    ) u_view (
      .idx(rp_idx[p]), .size(rp_size[p]), .hi(rp_hi[p]), .illegal(rp_bad[p])
    );

    gprf_read_slice #(.XLEN(XLEN)) u_slice (
      .word(rp_word[p]), .size(rp_size[p]), .hi(rp_hi[p]),
      .illegal(rp_bad[p]), .slice(rp_data[p])
    );
  end

  assign rd0_data    = rp_data[0];
  assign rd0_illegal = rp_bad[0];
  assign rd1_data    = rp_data[1];
  assign rd1_illegal = rp_bad[1];
  assign shift_count = regs_q[COUNT_REG][7:0];
endmodule

// File: rtl/gprf_checker.sv
module gprf_checker
  import gprf_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int XLEN  = 64,
  localparam int IW   = $clog2(NREGS)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [IW-1:0]              wr_idx,
  input logic [1:0]                 wr_size,
  input logic                       wr_illegal,
  input logic [IW-1:0]              rd0_idx,
  input logic [1:0]                 rd0_size,
  input logic [XLEN-1:0]            rd0_data,
  input logic                       rd0_illegal,
  input logic [NREGS-1:0][XLEN-1:0] regs_flat
);
  p_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_illegal && wr_size == ACC_B32)
      |=> (regs_flat[$past(wr_idx)][XLEN-1:32] == '0));

  p_upper_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_illegal && wr_size == ACC_B16)
      |=> (regs_flat[$past(wr_idx)][XLEN-1:16] == $past(regs_flat[wr_idx][XLEN-1:16])));

  p_bad_write_dropped_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_illegal) |=> (regs_flat == $past(regs_flat)));

  p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rd0_illegal |-> (rd0_data == '0));

  p_no_flag_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !wr_illegal);

  p_bypass_full_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_illegal && rd0_idx == wr_idx && rd0_size == ACC_B64)
      |=> (regs_flat[$past(wr_idx)] == $past(rd0_data)));
endmodule

bind gpr_slice_file gprf_checker #(.NREGS(NREGS), .XLEN(XLEN)) u_gprf_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
  .wr_illegal(wr_illegal), .rd0_idx(rd0_idx), .rd0_size(rd0_size),
  .rd0_data(rd0_data), .rd0_illegal(rd0_illegal), .regs_flat(regs_flat)
);

// File: tb/gpr_slice_file_bench.sv
module gpr_slice_file_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [1:0]  wr_size;
  logic        wr_hi;
  logic [63:0] wr_data;
  logic        wr_illegal;
  logic [3:0]  rd0_idx, rd1_idx;
  logic [1:0]  rd0_size, rd1_size;
  logic        rd0_hi, rd1_hi;
  logic [63:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;
  logic [7:0]  shift_count;

  int checks = 0;
  int failures = 0;
  logic [63:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_slice_file u_gpr_slice_file (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_hi(wr_hi), .wr_data(wr_data), .wr_illegal(wr_illegal),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
    .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi),
    .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
    .shift_count(shift_count)
  );

  function automatic bit view_bad(int idx, int sz, bit hi);
    if (sz != 0) return 1'b0;
    if (idx >= 4 && idx <= 7) return 1'b1;
    return hi && idx >= 4;
  endfunction

  function automatic logic [63:0] store_rule(logic [63:0] old, logic [63:0] d, int sz, bit hi);
    logic [63:0] r = old;
    if (sz == 3) r = d;
    else if (sz == 2) r = {32'h0, d[31:0]};
    else if (sz == 1) r[15:0] = d[15:0];
    else if (hi) r[15:8] = d[7:0];
    else r[7:0] = d[7:0];
    return r;
  endfunction

  function automatic logic [63:0] view_of(logic [63:0] w, int sz, bit hi);
    if (sz == 3) return w;
    if (sz == 2) return {32'h0, w[31:0]};
    if (sz == 1) return {48'h0, w[15:0]};
    return hi ? {56'h0, w[15:8]} : {56'h0, w[7:0]};
  endfunction

  function automatic string pick_tag(int idx, int sz, bit hi, bit byp);
    if (view_bad(idx, sz, hi)) return "R7";
    if (byp) return "R9";
    if (sz == 3) return "R2";
    if (sz == 2) return "R3";
    if (sz == 1) return hi ? "R8" : "R4";
    return hi ? "R6" : "R5";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic port_check(int idx, int sz, bit hi, logic [63:0] act_d, logic act_bad,
                            bit we, int widx, logic [63:0] wnext);
    bit byp = we && idx == widx;
    logic [63:0] w = byp ? wnext : model[idx];
    bit bad = view_bad(idx, sz, hi);
    string tag = pick_tag(idx, sz, hi, byp);
    check(tag, act_d, bad ? 64'h0 : view_of(w, sz, hi));
    check("R7", {63'h0, act_bad}, {63'h0, bad});
  endtask

  task automatic step(bit we, int widx, int wsz, bit whi, logic [63:0] wd,
                      int i0, int s0, bit h0, int i1, int s1, bit h1);
    bit wbad;
    bit wok;
    logic [63:0] wnext;
    @(negedge clk);
    wr_en = we; wr_idx = 4'(widx); wr_size = 2'(wsz); wr_hi = whi; wr_data = wd;
    rd0_idx = 4'(i0); rd0_size = 2'(s0); rd0_hi = h0;
    rd1_idx = 4'(i1); rd1_size = 2'(s1); rd1_hi = h1;
    #1;
    wbad  = view_bad(widx, wsz, whi);
    wok   = we && !wbad;
    wnext = store_rule(model[widx], wd, wsz, whi);
    check("R7", {63'h0, wr_illegal}, {63'h0, we && wbad});
    port_check(i0, s0, h0, rd0_data, rd0_illegal, wok, widx, wnext);
    port_check(i1, s1, h1, rd1_data, rd1_illegal, wok, widx, wnext);
    check("R10", {56'h0, shift_count}, {56'h0, model[1][7:0]});
    @(posedge clk);
    if (wok) model[widx] = wnext;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    foreach (model[k]) model[k] = 64'h0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic dump_all();
    for (int k = 0; k < 16; k += 2) step(0, 0, 3, 0, 64'h0, k, 3, 0, k + 1, 3, 0);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_hi = 1'b0; wr_data = '0;
    rd0_idx = '0; rd0_size = '0; rd0_hi = 1'b0; rd1_idx = '0; rd1_size = '0; rd1_hi = 1'b0;
    fork
      begin
        do_reset();
        // R1: everything reads zero after reset
        for (int k = 0; k < 16; k++) model[k] = 64'h0;
        dump_all();
        // R2, R3, R4: width rules on register 2
        step(1, 2, 3, 0, 64'hFEDC_BA98_7654_3210, 2, 3, 0, 2, 2, 0);
        step(1, 2, 2, 0, 64'h1111_2222_3333_4444, 2, 3, 0, 2, 1, 0);
        step(1, 2, 3, 0, 64'hAAAA_BBBB_CCCC_DDDD, 2, 3, 0, 2, 3, 0);
        step(1, 2, 1, 0, 64'h9999_8888_7777_1234, 2, 3, 0, 2, 1, 0);
        // R5, R6: low and second byte on registers 0..3 and 8..15
        step(1, 3, 3, 0, 64'h0123_4567_89AB_CDEF, 3, 0, 1, 3, 0, 0);
        step(1, 3, 0, 1, 64'h0000_0000_0000_005A, 3, 3, 0, 3, 0, 1);
        step(1, 3, 0, 0, 64'hFFFF_FFFF_FFFF_FFA5, 3, 3, 0, 3, 0, 0);
        step(1, 12, 0, 0, 64'h77, 12, 3, 0, 12, 0, 0);
        // R7: illegal byte views, writes dropped, reads zero
        step(1, 5, 3, 0, 64'hDEAD_BEEF_0000_0001, 5, 3, 0, 5, 0, 0);
        step(1, 5, 0, 0, 64'hFF, 5, 3, 0, 5, 0, 0);
        step(1, 9, 0, 1, 64'hEE, 9, 3, 0, 9, 0, 1);
        step(1, 6, 0, 1, 64'hCC, 6, 0, 1, 6, 3, 0);
        // R8: select ignored at 16-bit and 64-bit width
        step(1, 10, 1, 1, 64'h5555_6666_7777_ABCD, 10, 1, 1, 10, 3, 1);
        // R10: count output follows stored register 1
        step(1, 1, 0, 0, 64'h3F, 1, 0, 0, 1, 3, 0);
        step(1, 1, 0, 1, 64'h12, 1, 3, 0, 0, 3, 0);
        step(0, 1, 3, 0, 64'h0, 1, 0, 0, 1, 0, 1);
        // R9 and mixed traffic
        for (int n = 0; n < 3000; n++) begin
          int widx = $urandom_range(0, 15);
          int i0 = ($urandom_range(0, 2) == 0) ? widx : $urandom_range(0, 15);
          int i1 = ($urandom_range(0, 2) == 0) ? widx : $urandom_range(0, 15);
          step($urandom_range(0, 3) != 0, widx, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
               {$urandom, $urandom}, i0, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
               i1, $urandom_range(0, 3), 1'($urandom_range(0, 1)));
        end
        dump_all();
        // R1: reset again after traffic
        do_reset();
        dump_all();
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule